// File: doc/BRIEF.md
# Per-Core Banked Timer Access Router

This block holds a countdown timer and a watchdog-style countdown timer for each of `NCORES` processor cores. It puts all of them behind a single register address space. Every access carries the identifier of the core that issues it. Two banked windows at the bottom of the space are steered by that identifier, so the same address reaches a different physical instance depending on which core asks. Window 0 reaches the caller's own timer and window 1 reaches the caller's own watchdog. Above these, one direct window per instance lets any core reach any instance by position.

Each window is 32 bytes wide and holds four word registers: reload value, current count, control and status. Accesses are single 32-bit words. The router returns read data one cycle after the request. It raises a one-cycle fault pulse, instead of touching an instance, when any of these holds: the banked caller does not exist, the direct window lies beyond the instances built, or the address is not word aligned. The status bit of every instance drives its own line of an interrupt vector, and the lines follow the same order as the direct windows.

Top module: `mpt_bank_router`

## Requirements
- R1: An access to window 0 (byte addresses 0x00–0x1F) from core `c` reaches instance `2*c`, the timer of that core.
- R2: An access to window 1 (byte addresses 0x20–0x3F) from core `c` reaches instance `2*c+1`, the watchdog of that core.
- R3: Window `w >= 2` (byte address `w*0x20`) reaches instance `w-2` whatever the core identifier, so instances are ordered core 0 timer, core 0 watchdog, core 1 timer, and so on.
- R4: A banked-window access from a core identifier `>= NCORES` leaves every instance unchanged. A read of this kind returns zero. Either kind sets `acc_fault` high for exactly the cycle after the request.
- R5: An access to a direct window at or beyond `2+2*NCORES`, or with `acc_addr[1:0] != 0`, is faulted in the same way as R4.
- R6: A read (`acc_valid` high, `acc_write` low) gives `rsp_valid` high in the next cycle. `rsp_rdata` then holds the register value from before that edge. Offsets 0x10–0x1C inside a window read as zero, ignore writes and raise no fault. With no request, `rsp_valid` and `acc_fault` stay low.
- R7: `irq_out[2*c]` is the status bit of core `c`'s timer and `irq_out[2*c+1]` that of its watchdog.
- R8: Register offsets: 0x0 reload, 0x4 count, 0x8 control (bit 0 run, bit 1 auto-reload, bits 15:8 prescale `p`), 0xC status (bit 0). While running with a nonzero count, the count drops by one every `p+1` clocks. A step from 1 sets the status bit and loads the reload value if auto-reload is set, or 0 otherwise.
- R9: Writing the reload register also writes the count. Switching run from 0 to 1 with count 0 and auto-reload set copies the reload value into the count.
- R10: Writing 1 to status bit 0 clears it, unless an expiry sets it in the same cycle.
- R11: After reset every register of every instance is zero, `irq_out` is all zero, and no response or fault is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_core | input | CORE_W | Identifier of the requesting core |
| acc_addr | input | ADDR_W | Byte address into the window space |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | 32 | Read data |
| acc_fault | output | 1 | One-cycle pulse for a rejected access |
| irq_out | output | 2*NCORES | Per-instance interrupt lines, timer then watchdog per core |

## Verification
The bench builds the router with `NCORES = 3`, which is below the package maximum of 4. With this value, core identifiers 3 to 7 are legal bus values that must fault, and windows 8 and 9 exist in the address space but point at no instance. An odd core count also tests that the instance index for the last core lands on the upper bits of the interrupt vector. A prescale of 1 and of 0 brings both the divided and the undivided tick into a short run.

// File: rtl/mpt_pkg.sv
`timescale 1ns/1ps
package mpt_pkg;
    localparam int MAX_CORES = 4;
    localparam int DATA_W    = 32;
    localparam int WIN_BYTES = 32;
    localparam int WIN_LSB   = $clog2(WIN_BYTES);
    localparam int CORE_W    = $clog2(MAX_CORES) + 1;
    localparam int ADDR_W    = $clog2((2 + 2 * MAX_CORES) * WIN_BYTES);
    localparam int WIN_W     = ADDR_W - WIN_LSB;
    localparam int IDX_W     = (CORE_W + 1 > WIN_W) ? CORE_W + 1 : WIN_W;

    typedef enum logic [1:0] {
        WK_OWN_TMR,
        WK_OWN_WDG,
        WK_DIRECT
    } win_kind_e;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } tmr_reg_e;
endpackage

// File: rtl/mpt_win_decode.sv
`timescale 1ns/1ps
module mpt_win_decode
    import mpt_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic [CORE_W-1:0] core,
    input  logic [ADDR_W-1:0] addr,
    output logic              fault,
    output logic [IDX_W-1:0]  tgt,
    output tmr_reg_e          reg_sel,
    output logic              reg_hi
);
    localparam logic [CORE_W-1:0] NC_L     = CORE_W'(NCORES);
    localparam logic [WIN_W-1:0]  WIN_LIM  = WIN_W'(2 + 2 * NCORES);

    logic [WIN_W-1:0]   win;
    logic [WIN_LSB-1:0] off;
    win_kind_e          kind;
    logic               bad_tgt;

    assign win     = addr[ADDR_W-1:WIN_LSB];
    assign off     = addr[WIN_LSB-1:0];
    assign reg_hi  = off[4];
    assign reg_sel = tmr_reg_e'(off[3:2]);

    always_comb begin
        if (win == WIN_W'(0))      kind = WK_OWN_TMR;
        else if (win == WIN_W'(1)) kind = WK_OWN_WDG;
        else                       kind = WK_DIRECT;
    end

    always_comb begin
        unique case (kind)
            WK_OWN_TMR: begin
                tgt     = IDX_W'({core, 1'b0});
                bad_tgt = (core >= NC_L);
            end
            WK_OWN_WDG: begin
                tgt     = IDX_W'({core, 1'b1});
                bad_tgt = (core >= NC_L);
            end
            default: begin
                tgt     = IDX_W'(win - WIN_W'(2));
                bad_tgt = (win >= WIN_LIM);
            end
        endcase
        fault = bad_tgt | (off[1:0] != 2'b00);
    end
endmodule

// File: rtl/mpt_timer_unit.sv
`timescale 1ns/1ps
module mpt_timer_unit
    import mpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tmr_reg_e          reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [DATA_W-1:0] reload_q, reload_d, cnt_q, cnt_d;
    logic              run_q, run_d, auto_q, auto_d;
    logic [7:0]        presc_q, presc_d, pre_q, pre_d;
    logic              stat_q, stat_d;
    logic              expire;

    always_comb begin
        reload_d = reload_q;
        cnt_d    = cnt_q;
        run_d    = run_q;
        auto_d   = auto_q;
        presc_d  = presc_q;
        pre_d    = pre_q;
        expire   = 1'b0;

        if (run_q && cnt_q != '0) begin
            if (pre_q == 8'd0) begin
                pre_d = presc_q;
                if (cnt_q == DATA_W'(1)) begin
                    expire = 1'b1;
                    cnt_d  = auto_q ? reload_q : '0;
                end else begin
                    cnt_d = cnt_q - DATA_W'(1);
                end
            end else begin
                pre_d = pre_q - 8'd1;
            end
        end
        stat_d = stat_q | expire;

        if (wr_en) begin
            unique case (reg_sel)
                REG_RELOAD: begin
                    reload_d = wr_data;
                    cnt_d    = wr_data;
                    pre_d    = presc_q;
                end
                REG_COUNT: begin
                    cnt_d = wr_data;
                    pre_d = presc_q;
                end
                REG_CTRL: begin
                    run_d   = wr_data[0];
                    auto_d  = wr_data[1];
                    presc_d = wr_data[15:8];
                    if (!run_q && wr_data[0]) begin
                        pre_d = wr_data[15:8];
                        if (cnt_q == '0 && wr_data[1]) cnt_d = reload_q;
                    end
                end
                REG_STAT: stat_d = expire | (stat_q & ~wr_data[0]);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            auto_q   <= 1'b0;
            presc_q  <= '0;
            pre_q    <= '0;
            stat_q   <= 1'b0;
        end else begin
            reload_q <= reload_d;
            cnt_q    <= cnt_d;
            run_q    <= run_d;
            auto_q   <= auto_d;
            presc_q  <= presc_d;
            pre_q    <= pre_d;
            stat_q   <= stat_d;
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_RELOAD: rd_data = reload_q;
            REG_COUNT:  rd_data = cnt_q;
            REG_CTRL:   rd_data = {16'b0, presc_q, 6'b0, auto_q, run_q};
            REG_STAT:   rd_data = {31'b0, stat_q};
        endcase
    end

    assign irq = stat_q;
endmodule

// File: rtl/mpt_bank_router.sv
`timescale 1ns/1ps
module mpt_bank_router
    import mpt_pkg::*;
#(
    parameter int NCORES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [CORE_W-1:0]     acc_core,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [DATA_W-1:0]     acc_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic                  acc_fault,
    output logic [2*NCORES-1:0]   irq_out
);
    localparam int NINST = 2 * NCORES;

    logic              dec_fault;
    logic [IDX_W-1:0]  dec_tgt;
    tmr_reg_e          dec_reg;
    logic              dec_hi;
    logic              hit;
    logic [DATA_W-1:0] unit_rd [NINST];
    logic [DATA_W-1:0] rd_mux;

    mpt_win_decode #(.NCORES(NCORES)) u_dec (
        .core    (acc_core),
        .addr    (acc_addr),
        .fault   (dec_fault),
        .tgt     (dec_tgt),
        .reg_sel (dec_reg),
        .reg_hi  (dec_hi)
    );

    assign hit = acc_valid && !dec_fault && !dec_hi;

    for (genvar gi = 0; gi < NINST; gi++) begin : g_inst
        mpt_timer_unit u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hit && acc_write && (dec_tgt == IDX_W'(gi))),
            .reg_sel (dec_reg),
            .wr_data (acc_wdata),
            .rd_data (unit_rd[gi]),
            .irq     (irq_out[gi])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NINST; i++) begin
            if (dec_tgt == IDX_W'(i)) rd_mux = unit_rd[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            acc_fault <= 1'b0;
        end else begin
            rsp_valid <= acc_valid && !acc_write;
            rsp_rdata <= (hit && !acc_write) ? rd_mux : '0;
            acc_fault <= acc_valid && dec_fault;
        end
    end
endmodule

// File: rtl/mpt_router_chk.sv
`timescale 1ns/1ps
module mpt_router_chk
    import mpt_pkg::*;
#(
    parameter int NCORES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [CORE_W-1:0] acc_core,
    input logic [WIN_W-1:0]  acc_win,
    input logic [1:0]        acc_lo,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              acc_fault
);
    logic banked_oob;
    assign banked_oob = (acc_win < WIN_W'(2)) && (acc_core >= CORE_W'(NCORES));

    a_r4_banked_oob: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && banked_oob |=> acc_fault);

    a_r4_fault_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && acc_fault |-> rsp_rdata == '0);

    a_r5_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_lo != 2'b00 |=> acc_fault);

    a_r6_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rsp_valid);

    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid && !acc_fault);
endmodule

bind mpt_bank_router mpt_router_chk #(.NCORES(NCORES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_core  (acc_core),
    .acc_win   (acc_addr[mpt_pkg::ADDR_W-1:mpt_pkg::WIN_LSB]),
    .acc_lo    (acc_addr[1:0]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .acc_fault (acc_fault)
);

// File: tb/test_mpt_bank_router.sv
`timescale 1ns/1ps
module test_mpt_bank_router;
    import mpt_pkg::*;
    localparam int NC = 3;
    localparam int NI = 2 * NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              b_valid = 1'b0, b_write = 1'b0;
    logic [CORE_W-1:0] b_core  = '0;
    logic [ADDR_W-1:0] b_addr  = '0;
    logic [31:0]       b_wdata = '0;
    logic              rsp_valid, acc_fault;
    logic [31:0]       rsp_rdata;
    logic [NI-1:0]     irq_out;

    mpt_bank_router #(.NCORES(NC)) i_mpt_bank_router (
        .clk(clk), .rst_n(rst_n), .acc_valid(b_valid), .acc_write(b_write),
        .acc_core(b_core), .acc_addr(b_addr), .acc_wdata(b_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .acc_fault(acc_fault),
        .irq_out(irq_out)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 0;

    task automatic chk(string tag, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int unsigned m_load[NI], m_cnt[NI], m_presc[NI], m_pre[NI];
    bit          m_run[NI], m_auto[NI], m_stat[NI], m_exp[NI];
    bit          e_rv, e_flt;
    int unsigned e_rd;
    int          win, off, idx;
    bit          flt;
    int unsigned o_cnt, o_load, w;
    bit          o_run, o_stat;

    function automatic int unsigned mreg(int k, int r);
        case (r)
            0: return m_load[k];
            1: return m_cnt[k];
            2: return (m_presc[k] << 8) | (int'(m_auto[k]) << 1) | int'(m_run[k]);
            default: return int'(m_stat[k]);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NI; i++) begin
                m_load[i] = 0; m_cnt[i] = 0; m_presc[i] = 0; m_pre[i] = 0;
                m_run[i] = 0; m_auto[i] = 0; m_stat[i] = 0;
            end
            e_rv = 0; e_flt = 0; e_rd = 0;
        end else begin
            win = int'(b_addr) / 32;
            off = int'(b_addr) % 32;
            if (win < 2) begin
                idx = 2 * int'(b_core) + win;
                flt = int'(b_core) >= NC;
            end else begin
                idx = win - 2;
                flt = idx >= NI;
            end
            if (off % 4 != 0) flt = 1;
            e_flt = b_valid && flt;
            e_rv  = b_valid && !b_write;
            e_rd  = 0;
            if (e_rv && !flt && off < 16) e_rd = mreg(idx, off / 4);
            if (!flt) begin
                o_cnt = m_cnt[idx]; o_load = m_load[idx];
                o_run = m_run[idx]; o_stat = m_stat[idx];
            end
            for (int i = 0; i < NI; i++) begin
                m_exp[i] = 0;
                if (m_run[i] && m_cnt[i] != 0) begin
                    if (m_pre[i] == 0) begin
                        m_pre[i] = m_presc[i];
                        if (m_cnt[i] == 1) begin
                            m_exp[i] = 1; m_stat[i] = 1;
                            m_cnt[i] = m_auto[i] ? m_load[i] : 0;
                        end else m_cnt[i] = m_cnt[i] - 1;
                    end else m_pre[i] = m_pre[i] - 1;
                end
            end
            if (b_valid && b_write && !flt && off < 16) begin
                w = b_wdata;
                case (off / 4)
                    0: begin m_load[idx] = w; m_cnt[idx] = w; m_pre[idx] = m_presc[idx]; end
                    1: begin m_cnt[idx] = w; m_pre[idx] = m_presc[idx]; end
                    2: begin
                        m_run[idx] = w[0]; m_auto[idx] = w[1]; m_presc[idx] = (w >> 8) & 255;
                        if (!o_run && w[0]) begin
                            m_pre[idx] = m_presc[idx];
                            if (o_cnt == 0 && w[1]) m_cnt[idx] = o_load;
                        end
                    end
                    default: m_stat[idx] = m_exp[idx] | (o_stat & !w[0]);
                endcase
            end
        end
    end

    // compared on every clock, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NI-1:0] ev;
            for (int i = 0; i < NI; i++) ev[i] = m_stat[i];
            chk("R6", "rsp_valid", rsp_valid, e_rv);
            if (e_rv) chk("R6", "rsp_rdata", rsp_rdata, e_rd);
            chk("R4", "acc_fault", acc_fault, e_flt);
            chk("R7", "irq_out", irq_out, ev);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            total++; bad++;
            $display("FAIL R6 watchdog cycles=%0d expected below 20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(int core, int addr, int unsigned data, output bit f);
        b_valid = 1; b_write = 1; b_core = CORE_W'(core);
        b_addr = ADDR_W'(addr); b_wdata = data;
        @(negedge clk);
        f = acc_fault;
        b_valid = 0; b_write = 0;
    endtask

    task automatic rd(int core, int addr, output int unsigned v, output bit f);
        b_valid = 1; b_write = 0; b_core = CORE_W'(core); b_addr = ADDR_W'(addr);
        @(negedge clk);
        v = rsp_rdata; f = acc_fault;
        b_valid = 0;
    endtask

    initial begin
        int unsigned v;
        bit f;
        repeat (3) @(negedge clk);
        chk("R11", "irq in reset", irq_out, 0);
        chk("R11", "rsp_valid in reset", rsp_valid, 0);
        rst_n = 1;
        for (int k = 0; k < NI; k++) begin
            rd(0, (2 + k) * 32, v, f); chk("R11", "reload after reset", v, 0);
        end
        // R3: direct windows
        for (int k = 0; k < NI; k++) wr(0, (2 + k) * 32, 100 + k, f);
        for (int k = 0; k < NI; k++) begin
            rd(2, (2 + k) * 32, v, f); chk("R3", "direct reload", v, 100 + k);
        end
        // R1 / R2: banked steering
        for (int c = 0; c < NC; c++) begin
            rd(c, 0, v, f);  chk("R1", "own timer", v, 100 + 2 * c);
            rd(c, 32, v, f); chk("R2", "own watchdog", v, 101 + 2 * c);
        end
        wr(2, 0, 55, f);
        rd(0, (2 + 4) * 32, v, f); chk("R1", "banked write lands", v, 55);
        // R4: out-of-range core
        rd(3, 0, v, f);  chk("R4", "oob read data", v, 0); chk("R4", "oob read fault", f, 1);
        rd(7, 40, v, f); chk("R4", "oob read fault id7", f, 1);
        wr(5, 32, 999, f); chk("R4", "oob write fault", f, 1);
        wr(3, 0, 998, f);
        for (int k = 0; k < NI; k++) begin
            rd(0, (2 + k) * 32, v, f);
            chk("R4", "instances untouched", v, (k == 4) ? 55 : 100 + k);
        end
        // R5: unmapped window and misalignment
        rd(0, (2 + NI) * 32, v, f); chk("R5", "unmapped fault", f, 1); chk("R5", "unmapped data", v, 0);
        rd(1, 9 * 32, v, f);        chk("R5", "top window fault", f, 1);
        rd(0, 2 * 32 + 1, v, f);    chk("R5", "misaligned read", f, 1);
        wr(0, 2 * 32 + 2, 77, f);   chk("R5", "misaligned write", f, 1);
        rd(0, 2 * 32, v, f);        chk("R5", "misaligned write ignored", v, 100);
        // R6: upper offsets
        rd(0, 2 * 32 + 16, v, f);   chk("R6", "upper offset data", v, 0); chk("R6", "upper offset fault", f, 0);
        wr(0, 2 * 32 + 20, 5, f);   chk("R6", "upper offset write fault", f, 0);
        rd(0, 2 * 32, v, f);        chk("R6", "upper write ignored", v, 100);
        // R9: reload write also sets count
        wr(0, 4 * 32, 40, f);
        rd(0, 4 * 32 + 4, v, f);    chk("R9", "count follows reload", v, 40);
        // R8: one-shot, prescale 1
        wr(0, 0, 3, f);
        wr(0, 8, 32'h0101, f);
        repeat (12) @(negedge clk);
        rd(0, 4, v, f);             chk("R8", "one-shot count", v, 0);
        chk("R8", "expiry status", irq_out[0], 1);
        chk("R7", "timer line order", irq_out, 6'b000001);
        // R10: clear
        wr(0, 12, 1, f);            chk("R10", "status cleared", irq_out[0], 0);
        // R9: run edge with count 0 and auto-reload
        wr(0, 8, 0, f);
        wr(0, 8, 32'h0003, f);
        rd(0, 4, v, f);             chk("R9", "count reloaded on start", v, 3);
        repeat (20) @(negedge clk);
        rd(0, 8, v, f);             chk("R8", "control readback", v, 32'h0003);
        wr(0, 8, 0, f);
        wr(0, 12, 1, f);
        // R7: watchdog line of core 1
        wr(1, 32, 2, f);
        wr(1, 40, 32'h0001, f);
        repeat (6) @(negedge clk);
        chk("R7", "watchdog line order", irq_out, 6'b001000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule